// File: doc/BRIEF.md
# Bus Address Decoder with Timeout Error

This block sits beside a shared bus. Every target on that bus sees every request. The decoder compares the address of each new request against a set of inclusive address windows, one window per target. It then drives a one-hot select so that only the owning target answers. The address space has holes: memory fills the low part, and the device part above it is only sparsely used. An access that lands in a hole selects nobody.

A request begins with a single-cycle valid strobe. From that point the decoder waits for any target to acknowledge. If no acknowledge arrives within a parameterised number of cycles, the request ends in a bus error. A bus error is also raised at once when the window configuration lets two or more targets claim the same address.

The error flag stays up until the next strobe. The bus carries one request at a time, so a strobe that arrives while a request is still waiting is ignored.

The controller has three states:

- **IDLE**: no request is in flight.
- **WAIT**: a request has been accepted and the decoder is waiting for an acknowledge.
- **FAULT**: an error is being reported.

It has these transitions:

- *accept*: IDLE or FAULT goes to WAIT on a strobe whose address falls in at most one window.
- *clash*: IDLE or FAULT goes to FAULT on a strobe whose address falls in two or more windows.
- *answered*: WAIT goes to IDLE when any acknowledge is seen.
- *expired*: WAIT goes to FAULT when the timer runs out with no acknowledge.

Top module: `bus_addr_decoder`

## Requirements
- R1: With the default parameters, select bit 0 owns 0x000000..0x0FFFFF, bit 1 owns 0x100000..0x1FFFFF, bit 2 owns 0x200000..0x20000B and bit 3 owns 0x20000C..0x200017. Both bounds of each window are inclusive. The select bit of the owning target is high from the clock edge that samples the strobe.
- R2: At most one select bit is ever high. An accepted select holds steadily until the request ends.
- R3: An address inside no window (a hole) raises no select bit, and the request still runs through the timer.
- R4: Any acknowledge bit sampled high during WAIT ends the request. From that edge on, all selects are low and there is no error. This holds even when the acknowledge comes on the last cycle the timer allows.
- R5: If the strobe is sampled at edge 0 and no acknowledge is seen at edges 1..TIMEOUT, then bus_err is high and all selects are low from edge TIMEOUT on. TIMEOUT is 16 by default.
- R6: A strobe whose address lies in two or more windows selects nobody and raises bus_err from the edge that samples it.
- R7: bus_err stays high until a strobe is sampled. That strobe clears it, unless the new address itself clashes, and starts a new request.
- R8: A strobe sampled during WAIT changes neither the select nor the timer.
- R9: After reset, selects and bus_err are low. Acknowledges seen outside WAIT have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Single-cycle strobe that marks a new request |
| req_addr | input | ADDR_W | Request address, sampled together with the strobe |
| tgt_ack | input | N_TGT | Acknowledge from each target |
| tgt_sel | output | N_TGT | One-hot select of the owning target |
| bus_err | output | 1 | Bus error: timeout or overlapping windows |

## Verification
Selects and a clash error appear at the first edge after the strobe. A timeout error appears exactly TIMEOUT edges after the strobe. An acknowledge clears the outputs at the edge that samples it.

The bench drives every input at a falling edge and reads the outputs at the next falling edge. It steps one edge at a time and compares after each edge, so every result is checked in the cycle it is due. Windows are swept at their bounds, densely across the device region and by stride over the whole space. The acknowledge delay varies from 1 to TIMEOUT. A second instance with overlapping windows receives the same stimulus and is used to check clash reporting.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FAULT = 2'd2
    } dec_state_e;
endpackage

// File: rtl/dec_window_match.sv
module dec_window_match #(
    parameter int               ADDR_W = 24,
    parameter logic [ADDR_W-1:0] LO    = '0,
    parameter logic [ADDR_W-1:0] HI    = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic lo_ok;
    logic hi_ok;

    // Bounds at the ends of the space need no comparator.
    generate
        if (LO == '0) begin : g_lo_free
            assign lo_ok = 1'b1;
        end else begin : g_lo_cmp
            assign lo_ok = (addr >= LO);
        end
        if (HI == {ADDR_W{1'b1}}) begin : g_hi_free
            assign hi_ok = 1'b1;
        end else begin : g_hi_cmp
            assign hi_ok = (addr <= HI);
        end
    endgenerate

    assign hit = lo_ok & hi_ok;
endmodule

// File: rtl/dec_overlap_detect.sv
module dec_overlap_detect #(
    parameter int N_TGT = 4
) (
    input  logic [N_TGT-1:0] hits,
    output logic             multi
);
    logic seen;

    always_comb begin
        seen  = 1'b0;
        multi = 1'b0;
        for (int i = 0; i < N_TGT; i++) begin
            if (hits[i]) begin
                if (seen) begin
                    multi = 1'b1;
                end
                seen = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dec_txn_fsm.sv
module dec_txn_fsm
    import bus_dec_pkg::*;
#(
    parameter int N_TGT   = 4,
    parameter int TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [N_TGT-1:0] hits,
    input  logic             multi,
    input  logic [N_TGT-1:0] acks,
    output logic [N_TGT-1:0] sel,
    output logic             err
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    dec_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [N_TGT-1:0] match_q, match_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            match_q <= '0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            match_q <= match_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        match_nx = match_q;
        unique case (state)
            ST_IDLE, ST_FAULT: begin
                if (strobe) begin
                    cnt_nx = '0;
                    if (multi) begin
                        state_nx = ST_FAULT;          // clash
                        match_nx = '0;
                    end else begin
                        state_nx = ST_WAIT;           // accept
                        match_nx = hits;
                    end
                end
            end
            ST_WAIT: begin
                if (|acks) begin
                    state_nx = ST_IDLE;               // answered
                    match_nx = '0;
                end else if (cnt == CNT_LAST) begin
                    state_nx = ST_FAULT;              // expired
                    match_nx = '0;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            default: begin
                state_nx = ST_IDLE;
                match_nx = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        sel = (state == ST_WAIT) ? match_q : '0;
        err = (state == ST_FAULT);
    end

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    a_r1_sel_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT && strobe && !multi) |=> (sel == $past(hits)));

    a_r3_hole_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT && strobe && hits == '0) |=> (sel == '0));

    a_r4_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && |acks) |=> (sel == '0 && !err));

    a_r5_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (cnt <= CNT_LAST));

    a_r6_clash_err: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT && strobe && multi) |=> (err && sel == '0));

    a_r7_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !strobe) |=> err);

    a_r8_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !(|acks) && cnt != CNT_LAST) |=> $stable(sel));
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder #(
    parameter int ADDR_W  = 24,
    parameter int N_TGT   = 4,
    parameter int TIMEOUT = 16,
    parameter logic [N_TGT*ADDR_W-1:0] RANGE_BASE =
        {24'h20000C, 24'h200000, 24'h100000, 24'h000000},
    parameter logic [N_TGT*ADDR_W-1:0] RANGE_LAST =
        {24'h200017, 24'h20000B, 24'h1FFFFF, 24'h0FFFFF}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [N_TGT-1:0]  tgt_ack,
    output logic [N_TGT-1:0]  tgt_sel,
    output logic              bus_err
);
    logic [N_TGT-1:0] hits;
    logic             multi;

    generate
        for (genvar i = 0; i < N_TGT; i++) begin : g_win
            dec_window_match #(
                .ADDR_W (ADDR_W),
                .LO     (RANGE_BASE[i*ADDR_W +: ADDR_W]),
                .HI     (RANGE_LAST[i*ADDR_W +: ADDR_W])
            ) i_match (
                .addr (req_addr),
                .hit  (hits[i])
            );
        end
    endgenerate

    dec_overlap_detect #(.N_TGT(N_TGT)) i_overlap (
        .hits  (hits),
        .multi (multi)
    );

    dec_txn_fsm #(.N_TGT(N_TGT), .TIMEOUT(TIMEOUT)) i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (req_valid),
        .hits   (hits),
        .multi  (multi),
        .acks   (tgt_ack),
        .sel    (tgt_sel),
        .err    (bus_err)
    );

    a_r9_quiet_in_reset: assert property (@(posedge clk)
        (!rst_n) |-> (tgt_sel == '0 && !bus_err));
endmodule

// File: tb/test_bus_addr_decoder.sv
module test_bus_addr_decoder;
    localparam int TO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  tgt_ack = '0;
    logic [3:0]  sel_m, sel_o;
    logic        err_m, err_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [23:0] M_LO [4] = '{24'h000000, 24'h100000, 24'h200000, 24'h20000C};
    localparam logic [23:0] M_HI [4] = '{24'h0FFFFF, 24'h1FFFFF, 24'h20000B, 24'h200017};
    localparam logic [23:0] O_LO [4] = '{24'h000000, 24'h080000, 24'h200000, 24'h200008};
    localparam logic [23:0] O_HI [4] = '{24'h0FFFFF, 24'h17FFFF, 24'h20000B, 24'h20000F};

    always #5 clk = ~clk;

    bus_addr_decoder #(.TIMEOUT(TO)) i_bus_addr_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .tgt_ack(tgt_ack), .tgt_sel(sel_m), .bus_err(err_m)
    );

    bus_addr_decoder #(
        .TIMEOUT    (TO),
        .RANGE_BASE ({24'h200008, 24'h200000, 24'h080000, 24'h000000}),
        .RANGE_LAST ({24'h20000F, 24'h20000B, 24'h17FFFF, 24'h0FFFFF})
    ) i_bus_addr_decoder_ovl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .tgt_ack(tgt_ack), .tgt_sel(sel_o), .bus_err(err_o)
    );

    function automatic logic [3:0] hits_of(input logic [23:0] a, input bit ovl);
        logic [3:0] h;
        for (int i = 0; i < 4; i++) begin
            h[i] = ovl ? (a >= O_LO[i] && a <= O_HI[i]) : (a >= M_LO[i] && a <= M_HI[i]);
        end
        return h;
    endfunction

    task automatic check(input string tag, input logic [23:0] a,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%06h actual=%0h expected=%0h", tag, a, act, exp);
        end
    endtask

    // One request; ackd = edge of acknowledge (0 = never), rk = edge of a stray strobe.
    task automatic txn(input logic [23:0] a, input int ackd, input int rk, input logic [23:0] a2);
        logic [3:0] eh, oh;
        bit oc;
        eh = hits_of(a, 1'b0);
        oh = hits_of(a, 1'b1);
        oc = ($countones(oh) > 1);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check((eh == 0) ? "R3 hole select" : "R1 select", a, {28'd0, sel_m}, {28'd0, eh});
        check("R7 error cleared by strobe", a, {31'd0, err_m}, 32'd0);
        check("R6 overlap error", a, {31'd0, err_o}, {31'd0, oc});
        check("R6 overlap select", a, {28'd0, sel_o}, oc ? 32'd0 : {28'd0, oh});
        for (int k = 1; k <= TO; k++) begin
            if (k == ackd) tgt_ack = 4'b0001 << (k % 4);
            if (k == rk) begin
                req_valid = 1'b1;
                req_addr  = a2;
            end
            @(negedge clk);
            tgt_ack   = '0;
            req_valid = 1'b0;
            if (k == ackd) begin
                check("R4 ack clears select", a, {28'd0, sel_m}, 32'd0);
                check("R4 ack no error", a, {31'd0, err_m}, 32'd0);
                break;
            end else if (k == TO) begin
                check("R5 timeout error", a, {31'd0, err_m}, 32'd1);
                check("R5 timeout select low", a, {28'd0, sel_m}, 32'd0);
            end else begin
                check((rk != 0 && k >= rk) ? "R8 stray strobe ignored" : "R2 select held",
                      a, {27'd0, err_m, sel_m}, {28'd0, eh});
            end
        end
        check("R6 overlap final error", a, {31'd0, err_o}, {31'd0, (oc || ackd == 0)});
        check("R6 overlap final select", a, {28'd0, sel_o}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset select", 24'h0, {28'd0, sel_m}, 32'd0);
        check("R9 reset error", 24'h0, {31'd0, err_m}, 32'd0);
        rst_n = 1'b1;
        tgt_ack = 4'hF;
        repeat (2) @(negedge clk);
        tgt_ack = '0;
        @(negedge clk);
        check("R9 idle ack ignored", 24'h0, {27'd0, err_m, sel_m}, 32'd0);

        // Window bounds
        for (int i = 0; i < 4; i++) begin
            for (int d = -1; d <= 1; d++) begin
                if (!(i == 0 && d < 0)) txn(24'(int'(M_LO[i]) + d), 3, 0, '0);
                txn(24'(int'(M_HI[i]) + d), 2 + i, 0, '0);
            end
        end
        // Overlap boundaries and top of space
        txn(24'h07FFFF, 4, 0, '0);
        txn(24'h080000, 4, 0, '0);
        txn(24'h100000, 4, 0, '0);
        txn(24'hFFFFFF, 0, 0, '0);
        // Dense sweep across the device region
        for (int a = 24'h1FFFFC; a <= 24'h20001B; a++) begin
            txn(24'(a), (hits_of(24'(a), 1'b0) != 0) ? ((a % TO) + 1) : 0, 0, '0);
        end
        // Stride sweep over the whole space
        for (int j = 0; j < 240; j++) begin
            logic [23:0] a;
            a = 24'(j * 24'h11111);
            txn(a, (hits_of(a, 1'b0) != 0) ? ((j % TO) + 1) : 0, 0, '0);
        end
        // Stray strobes during WAIT: one acked, one timing out
        txn(24'h000010, 9, 3, 24'h20000C);
        txn(24'h100020, 0, 5, 24'h200004);
        // Error persists without a strobe
        repeat (4) @(negedge clk);
        check("R7 error held", 24'h100020, {31'd0, err_m}, 32'd1);
        txn(24'h200010, 1, 0, '0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule